// File: doc/BRIEF.md
# DDR Read Burst Capture

This block is the controller-side receive path for one read burst from a double-data-rate memory. A user request is turned into a READ command, held for one command period on the command bus, and the block then waits out the programmed CAS latency. It watches the memory's strobe, accepts the burst only if the strobe is driven low through the preamble window, and captures one data word per strobe transition until the selected burst length is reached. It then confirms the strobe stays low for the postamble and delivers the packed burst with a one-cycle valid pulse. Any malformed strobe instead ends the transfer with a one-cycle error pulse.

The model runs on a single clock at twice the command rate. One command period is two clock cycles, and each data beat occupies one clock cycle. Strobe and data are sampled directly on this clock. Delay calibration, DLL alignment and any clock-domain crossing of the strobe are handled elsewhere.

Top module: `ddr_rd_capture`

## Requirements
- R1: After synchronous reset, `rd_ready_o` is 1, `cmd_o` is NOP (2'b00), `cmd_addr_o` is 0, and `burst_valid_o` and `burst_err_o` are 0.
- R2: A request accepted at clock edge E0 drives `cmd_o` = READ (2'b01) with `cmd_addr_o` = the request address for exactly the two cycles after E0. In every other cycle `cmd_o` is NOP and `cmd_addr_o` is 0.
- R3: `rd_ready_o` is 0 from the cycle after acceptance until the cycle that carries the valid or error pulse. `rd_req_i` has no effect while the block is busy.
- R4: Counting cycles from 0 after E0, the first data beat is sampled in cycle 2*CL. CL comes from `cl_i` at acceptance and covers the range 2 to 7; values 0 and 1 act as 2.
- R5: The strobe must be driven (`dqs_oe_i`=1) and low in both cycles 2*CL-2 and 2*CL-1. Otherwise `burst_err_o` pulses in the following cycle, no valid is given, and the block returns to idle.
- R6: Beat j (cycle 2*CL+j) needs a driven strobe whose level differs from the previous cycle's sample. Its `dq_i` word is stored in `burst_o[j*DW +: DW]`. A beat without a strobe transition raises the error pulse in the next cycle.
- R7: `bl_sel_i` selects the burst length: 2'b00 gives 2 beats, 2'b01 gives 4, and 2'b10 or 2'b11 give 8. Words above the burst length read as zero.
- R8: In the two cycles after the last beat, the strobe must be driven low. Otherwise the error pulse follows in the next cycle.
- R9: On a well-formed burst, `burst_valid_o` is high for exactly one cycle, cycle 2*CL+BL+2, and `rd_ready_o` is 1 in that same cycle. Valid and error are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the command rate |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req_i | input | 1 | Read request, taken when ready |
| rd_addr_i | input | AW | Address sent with the READ |
| cl_i | input | CLW | CAS latency in command periods |
| bl_sel_i | input | 2 | Burst length select |
| rd_ready_o | output | 1 | Idle, a request can be taken |
| cmd_o | output | 2 | Command bus, NOP=00, READ=01 |
| cmd_addr_o | output | AW | Address bus, zero on NOP |
| dqs_i | input | 1 | Sampled strobe level |
| dqs_oe_i | input | 1 | Strobe is driven by the memory |
| dq_i | input | DW | Sampled data word |
| burst_o | output | 8*DW | Packed burst, word j at j*DW |
| burst_valid_o | output | 1 | One-cycle burst delivered pulse |
| burst_err_o | output | 1 | One-cycle malformed burst pulse |

## Verification
Well-formed bursts are run across every latency, including the clamped values 0 and 1, and across all four length codes. These runs use random data and random strobe levels while the strobe is undriven, so they separate correct latency counting and word placement from off-by-one timing. Directed faults place a high or undriven strobe in either preamble cycle, drop a strobe transition at the first beat and at an inner beat, and raise the strobe in either postamble cycle. Each fault tells apart a check made in the correct window from one made a cycle early or late. Random requests held during busy periods show that a second READ cannot start before the postamble ends.

// File: rtl/ddr_rd_pkg.sv
// Package: shared types and helpers for the DDR read burst capture.
// Assumes one command period equals two clock cycles.
package ddr_rd_pkg;

    localparam int BEATS_MAX = 8;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_READ = 2'b01
    } cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_LAT,
        PH_PRE,
        PH_DATA,
        PH_POST
    } phase_e;

    // Map the length select code to a beat count.
    function automatic int unsigned beats_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return 2;
            2'b01:   return 4;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/ddr_rd_timer.sv
// Module: sequencer for one read burst. It walks through command, latency,
// preamble, data and postamble phases and raises the valid or error pulse.
// Assumes the strobe checks arrive as qualified flags from the strobe monitor.
module ddr_rd_timer
    import ddr_rd_pkg::*;
#(
    parameter int CLW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic [CLW-1:0]      cl_i,
    input  logic [1:0]          bl_sel_i,
    input  logic                low_ok_i,
    input  logic                beat_ok_i,
    output phase_e              phase_o,
    output logic [2:0]          beat_idx_o,
    output logic [2:0]          beat_last_o,
    output logic                start_o,
    output logic                ready_o,
    output logic                valid_o,
    output logic                err_o
);

    localparam int CNTW = (CLW + 1 > 3) ? CLW + 1 : 3;

    phase_e            phase_q;
    logic [CNTW-1:0]   cnt_q;
    logic [CNTW-1:0]   lat_len_q;
    logic [2:0]        beat_last_q;
    logic [CLW-1:0]    cl_eff;
    logic [CNTW-1:0]   lat_len_d;

    // Clamp the latency to its minimum and derive the wait length.
    always_comb begin
        cl_eff    = (cl_i < CLW'(2)) ? CLW'(2) : cl_i;
        lat_len_d = CNTW'({cl_eff, 1'b0}) - CNTW'(4);
    end

    // Accept a request only while idle.
    always_comb begin
        start_o = (phase_q == PH_IDLE) && req_i;
        ready_o = (phase_q == PH_IDLE);
    end

    // Phase sequencing, counters and the result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            cnt_q       <= '0;
            lat_len_q   <= '0;
            beat_last_q <= '0;
            valid_o     <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (req_i) begin
                        phase_q     <= PH_CMD;
                        cnt_q       <= '0;
                        lat_len_q   <= lat_len_d;
                        beat_last_q <= 3'(beats_of(bl_sel_i) - 1);
                    end
                end
                PH_CMD: begin
                    if (cnt_q == CNTW'(1)) begin
                        cnt_q   <= '0;
                        phase_q <= (lat_len_q == '0) ? PH_PRE : PH_LAT;
                    end else begin
                        cnt_q <= cnt_q + CNTW'(1);
                    end
                end
                PH_LAT: begin
                    if (cnt_q == lat_len_q - CNTW'(1)) begin
                        cnt_q   <= '0;
                        phase_q <= PH_PRE;
                    end else begin
                        cnt_q <= cnt_q + CNTW'(1);
                    end
                end
                PH_PRE: begin
                    if (!low_ok_i) begin
                        err_o   <= 1'b1;
                        phase_q <= PH_IDLE;
                    end else if (cnt_q == CNTW'(1)) begin
                        cnt_q   <= '0;
                        phase_q <= PH_DATA;
                    end else begin
                        cnt_q <= cnt_q + CNTW'(1);
                    end
                end
                PH_DATA: begin
                    if (!beat_ok_i) begin
                        err_o   <= 1'b1;
                        phase_q <= PH_IDLE;
                    end else if (cnt_q == CNTW'(beat_last_q)) begin
                        cnt_q   <= '0;
                        phase_q <= PH_POST;
                    end else begin
                        cnt_q <= cnt_q + CNTW'(1);
                    end
                end
                PH_POST: begin
                    if (!low_ok_i) begin
                        err_o   <= 1'b1;
                        phase_q <= PH_IDLE;
                    end else if (cnt_q == CNTW'(1)) begin
                        valid_o <= 1'b1;
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + CNTW'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o     = phase_q;
    assign beat_idx_o  = cnt_q[2:0];
    assign beat_last_o = beat_last_q;

    // R9: the valid pulse lasts a single cycle.
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R9: valid and error are mutually exclusive.
    p_valid_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));

    // R3: an accepted request makes the block busy on the next cycle.
    p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && req_i) |=> (!ready_o && phase_q == PH_CMD));

    // R2: the command phase lasts exactly two cycles.
    p_cmd_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CMD && $past(phase_q == PH_CMD)) |=> (phase_q != PH_CMD));

    // R5: a bad preamble sample ends the burst with an error.
    p_pre_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PRE && !low_ok_i) |=> (err_o && ready_o));

endmodule

// File: rtl/ddr_rd_strobe_mon.sv
// Module: strobe monitor. It keeps the previous strobe sample and reports
// whether the strobe is driven low (preamble/postamble) or has toggled (beat).
// Assumes one sample per clock cycle.
module ddr_rd_strobe_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic dqs_i,
    input  logic dqs_oe_i,
    output logic low_ok_o,
    output logic beat_ok_o
);

    logic dqs_prev_q;

    // Remember the last strobe level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dqs_prev_q <= 1'b0;
        else        dqs_prev_q <= dqs_i;
    end

    // Qualify the current sample against the previous one.
    always_comb begin
        low_ok_o  = dqs_oe_i && !dqs_i;
        beat_ok_o = dqs_oe_i && (dqs_i != dqs_prev_q);
    end

endmodule

// File: rtl/ddr_rd_packer.sv
// Module: burst packer. It places each captured word in its slot and clears
// all slots at the start of a new burst. Assumes the slot index is in range.
module ddr_rd_packer #(
    parameter int DW    = 16,
    parameter int SLOTS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  wr_i,
    input  logic [2:0]            idx_i,
    input  logic [2:0]            last_i,
    input  logic [DW-1:0]         dq_i,
    output logic [SLOTS*DW-1:0]   burst_o
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Load slot g on its beat, clear it when a burst starts.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i)               burst_o[g*DW +: DW] <= '0;
            else if (wr_i && idx_i == 3'(g))     burst_o[g*DW +: DW] <= dq_i;
        end
    end

    // R7: a write never targets a slot beyond the selected burst length.
    p_slot_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> (idx_i <= last_i));

endmodule

// File: rtl/ddr_rd_capture.sv
// Module: top of the DDR read burst capture. It issues the READ, then joins
// the sequencer, strobe monitor and packer. Assumes a clock at twice the
// command rate and strobe/data already sampled on that clock.
module ddr_rd_capture
    import ddr_rd_pkg::*;
#(
    parameter int DW  = 16,
    parameter int AW  = 13,
    parameter int CLW = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_req_i,
    input  logic [AW-1:0]           rd_addr_i,
    input  logic [CLW-1:0]          cl_i,
    input  logic [1:0]              bl_sel_i,
    output logic                    rd_ready_o,
    output logic [1:0]              cmd_o,
    output logic [AW-1:0]           cmd_addr_o,
    input  logic                    dqs_i,
    input  logic                    dqs_oe_i,
    input  logic [DW-1:0]           dq_i,
    output logic [BEATS_MAX*DW-1:0] burst_o,
    output logic                    burst_valid_o,
    output logic                    burst_err_o
);

    phase_e         phase;
    logic [2:0]     beat_idx;
    logic [2:0]     beat_last;
    logic           start;
    logic           low_ok;
    logic           beat_ok;
    logic [AW-1:0]  addr_q;

    ddr_rd_timer #(.CLW(CLW)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (rd_req_i),
        .cl_i       (cl_i),
        .bl_sel_i   (bl_sel_i),
        .low_ok_i   (low_ok),
        .beat_ok_i  (beat_ok),
        .phase_o    (phase),
        .beat_idx_o (beat_idx),
        .beat_last_o(beat_last),
        .start_o    (start),
        .ready_o    (rd_ready_o),
        .valid_o    (burst_valid_o),
        .err_o      (burst_err_o)
    );

    ddr_rd_strobe_mon i_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .dqs_i    (dqs_i),
        .dqs_oe_i (dqs_oe_i),
        .low_ok_o (low_ok),
        .beat_ok_o(beat_ok)
    );

    ddr_rd_packer #(.DW(DW), .SLOTS(BEATS_MAX)) i_packer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(start),
        .wr_i   (phase == PH_DATA && beat_ok),
        .idx_i  (beat_idx),
        .last_i (beat_last),
        .dq_i   (dq_i),
        .burst_o(burst_o)
    );

    // Hold the request address for the command period.
    always_ff @(posedge clk) begin
        if (!rst_n)     addr_q <= '0;
        else if (start) addr_q <= rd_addr_i;
    end

    // Drive READ during the command phase, NOP with a zero address otherwise.
    always_comb begin
        cmd_o      = (phase == PH_CMD) ? CMD_READ : CMD_NOP;
        cmd_addr_o = (phase == PH_CMD) ? addr_q : '0;
    end

    // R2: the command bus leaves READ only after two cycles of it.
    p_read_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_READ && $past(cmd_o) == CMD_NOP) |=> (cmd_o == CMD_READ));

    // R3: no READ is issued while the block is idle.
    p_read_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready_o |-> (cmd_o == CMD_NOP));

endmodule

// File: tb/test_ddr_rd_capture.sv
module test_ddr_rd_capture;

    localparam int DW = 16;
    localparam int AW = 13;
    localparam int CLW = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           rd_req_i;
    logic [AW-1:0]  rd_addr_i;
    logic [CLW-1:0] cl_i;
    logic [1:0]     bl_sel_i;
    logic           rd_ready_o;
    logic [1:0]     cmd_o;
    logic [AW-1:0]  cmd_addr_o;
    logic           dqs_i;
    logic           dqs_oe_i;
    logic [DW-1:0]  dq_i;
    logic [8*DW-1:0] burst_o;
    logic           burst_valid_o;
    logic           burst_err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    ddr_rd_capture #(.DW(DW), .AW(AW), .CLW(CLW)) i_ddr_rd_capture (
        .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req_i), .rd_addr_i(rd_addr_i),
        .cl_i(cl_i), .bl_sel_i(bl_sel_i), .rd_ready_o(rd_ready_o),
        .cmd_o(cmd_o), .cmd_addr_o(cmd_addr_o), .dqs_i(dqs_i),
        .dqs_oe_i(dqs_oe_i), .dq_i(dq_i), .burst_o(burst_o),
        .burst_valid_o(burst_valid_o), .burst_err_o(burst_err_o)
    );

    task automatic chk(input string tag, input logic [8*DW-1:0] act,
                       input logic [8*DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int eff_cl(input logic [2:0] c);
        return (c < 3'd2) ? 2 : int'(c);
    endfunction

    function automatic int beats(input logic [1:0] s);
        return (s == 2'b00) ? 2 : (s == 2'b01) ? 4 : 8;
    endfunction

    // fault: 0 none, 1 preamble high, 2 missing beat edge, 3 postamble high,
    //        4 preamble undriven. fpos picks the cycle or beat.
    task automatic run_burst(input logic [AW-1:0] a, input logic [2:0] c,
                             input logic [1:0] s, input int fault, input int fpos);
        logic [DW-1:0]   w [8];
        logic [8*DW-1:0] exp_b;
        int cl, bl, fin;
        cl = eff_cl(c);
        bl = beats(s);
        exp_b = '0;
        for (int i = 0; i < 8; i++) begin
            w[i] = DW'($urandom);
            if (i < bl) exp_b[i*DW +: DW] = w[i];
        end
        case (fault)
            1, 4:    fin = 2*cl - 2 + fpos + 1;
            2:       fin = 2*cl + fpos + 1;
            3:       fin = 2*cl + bl + fpos + 1;
            default: fin = 2*cl + bl + 2;
        endcase
        @(negedge clk);
        chk("R3 ready before request", {127'b0, rd_ready_o}, 1);
        rd_req_i = 1'b1; rd_addr_i = a; cl_i = c; bl_sel_i = s;
        dqs_oe_i = 1'b0;
        @(posedge clk);
        for (int k = 0; k <= fin; k++) begin
            @(negedge clk);
            chk("R2 R4 command", {126'b0, cmd_o}, (k < 2) ? 1 : 0);
            chk("R2 address", {115'b0, cmd_addr_o}, (k < 2) ? {115'b0, a} : 0);
            chk("R3 ready", {127'b0, rd_ready_o}, (k == fin) ? 1 : 0);
            chk("R9 valid", {127'b0, burst_valid_o}, (k == fin && fault == 0) ? 1 : 0);
            chk("R5 R6 R8 error", {127'b0, burst_err_o}, (k == fin && fault != 0) ? 1 : 0);
            if (k == fin && fault == 0) chk("R6 R7 burst data", burst_o, exp_b);
            rd_req_i  = (k == fin) ? 1'b0 : 1'($urandom);
            rd_addr_i = AW'($urandom);
            dq_i      = DW'($urandom);
            dqs_oe_i  = 1'b0;
            dqs_i     = 1'($urandom);
            if (k >= 2*cl - 2 && k < 2*cl) begin
                dqs_oe_i = 1'b1; dqs_i = 1'b0;
                if (fault == 1 && k == 2*cl - 2 + fpos) dqs_i = 1'b1;
                if (fault == 4 && k == 2*cl - 2 + fpos) dqs_oe_i = 1'b0;
            end else if (k >= 2*cl && k < 2*cl + bl) begin
                dqs_oe_i = 1'b1;
                dqs_i = ~1'((k - 2*cl) % 2);
                dq_i = w[k - 2*cl];
                if (fault == 2 && k == 2*cl + fpos) dqs_i = 1'(fpos % 2);
            end else if (k >= 2*cl + bl && k < 2*cl + bl + 2) begin
                dqs_oe_i = 1'b1; dqs_i = 1'b0;
                if (fault == 3 && k == 2*cl + bl + fpos) dqs_i = 1'b1;
            end
        end
        dqs_oe_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; rd_req_i = 1'b0; rd_addr_i = '0; cl_i = 3'd3;
        bl_sel_i = 2'b01; dqs_i = 1'b0; dqs_oe_i = 1'b0; dq_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset ready", {127'b0, rd_ready_o}, 1);
        chk("R1 reset cmd", {126'b0, cmd_o}, 0);
        chk("R1 reset addr", {115'b0, cmd_addr_o}, 0);
        chk("R1 reset valid", {127'b0, burst_valid_o}, 0);
        chk("R1 reset err", {127'b0, burst_err_o}, 0);
        rst_n = 1'b1;
        // Directed: latency and length corners (R4, R7).
        run_burst(13'h0123, 3'd3, 2'b01, 0, 0);
        run_burst(13'h1FFF, 3'd2, 2'b00, 0, 0);
        run_burst(13'h0A5A, 3'd7, 2'b10, 0, 0);
        run_burst(13'h0001, 3'd0, 2'b10, 0, 0);
        run_burst(13'h0002, 3'd1, 2'b11, 0, 0);
        // Directed: malformed strobe (R5, R6, R8).
        run_burst(13'h0010, 3'd3, 2'b01, 1, 0);
        run_burst(13'h0011, 3'd3, 2'b01, 1, 1);
        run_burst(13'h0012, 3'd4, 2'b00, 4, 1);
        run_burst(13'h0013, 3'd2, 2'b10, 2, 0);
        run_burst(13'h0014, 3'd5, 2'b10, 2, 5);
        run_burst(13'h0015, 3'd3, 2'b01, 3, 0);
        run_burst(13'h0016, 3'd6, 2'b10, 3, 1);
        run_burst(13'h0017, 3'd3, 2'b01, 0, 0);
        // Random mix.
        for (int n = 0; n < 60; n++) begin
            logic [1:0] s;
            int f, p;
            s = 2'($urandom);
            f = ($urandom % 3 == 0) ? int'($urandom % 4) + 1 : 0;
            p = (f == 2) ? int'($urandom % beats(s)) : int'($urandom % 2);
            run_burst(AW'($urandom), 3'($urandom), s, f, p);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule